// File: doc/BRIEF.md
# ECC Error Diagnostic Logger

This block sits beside an ECC check-and-correct core and records what that core reports. It runs on its own diagnostic clock. On every rising edge it samples the core's error and multiple-error indications, the syndrome, the received check bits and the 64-bit data word.

It keeps three kinds of record. A saturating error counter counts the edges on which an error is present. A set of frozen registers captures the check bits, syndrome, error type and full data word of the first error after a clear, and then holds them. A live syndrome register takes the syndrome on every edge, whether or not an error is present. A captured flag tells software that the frozen set is valid.

A synchronous clear zeroes the counter and the frozen set, and re-arms the capture. Decoding these registers onto a readback bus is done outside this block.

The capture control is a two-state machine:
- `CAP_ARMED` waits for an error. The transition `ARMED_TO_FROZEN` fires on an error edge without clear.
- `CAP_FROZEN` holds the captured values. The transition `FROZEN_TO_ARMED` fires on clear.
- A clear in `CAP_ARMED` keeps the machine in `CAP_ARMED`. This is `ARMED_STAY_CLEAR`.

Top module: `ecc_diag_logger`

## Requirements
- R1: While `rst_n` is low, every output is zero and `captured` is 0.
- R2: On each rising edge without `clr`, where `err_in` or `merr_in` is high and the count is below 15, `err_count` increments by one.
- R3: `err_count` saturates at 15. Further error edges leave it at 15.
- R4: On the first error edge after reset or clear, the block does all of the following:
  - `frz_chk` takes `chk_in`.
  - `frz_syn` takes `syn_in`.
  - `frz_data` takes `data_in`.
  - `frz_type` takes the error type.
  - `captured` becomes 1.
- R5: While `captured` is 1 and `clr` is low, `frz_chk`, `frz_syn`, `frz_type` and `frz_data` do not change, whatever errors arrive.
- R6: `live_syn` takes `syn_in` on every rising edge out of reset, including edges with no error and edges with `clr`.
- R7: The error type is encoded as follows:
  - 2'b00 when there is no error.
  - 2'b01 when `err_in` is high and `merr_in` is low (single-bit error).
  - 2'b10 whenever `merr_in` is high, regardless of `err_in`.
- R8: An edge with `clr` high does all of the following, even when an error is present on that edge:
  - It zeroes `err_count`, `frz_chk`, `frz_syn`, `frz_type` and `frz_data`.
  - It sets `captured` to 0.
  - It neither counts nor captures that edge's error.
- R9: While no error has been seen since reset or clear, the frozen registers stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Diagnostic clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous diagnostic clear |
| err_in | input | 1 | Error present |
| merr_in | input | 1 | Multiple-bit error present |
| syn_in | input | 8 | Syndrome from the ECC core |
| chk_in | input | 8 | Check bits read from memory |
| data_in | input | 64 | Data word read from memory |
| err_count | output | 4 | Saturating error count |
| captured | output | 1 | Frozen set holds a first error |
| frz_chk | output | 8 | Check bits of first error |
| frz_syn | output | 8 | Syndrome of first error |
| frz_type | output | 2 | Type of first error |
| frz_data | output | 64 | Data word of first error |
| live_syn | output | 8 | Syndrome of the most recent edge |

## Verification
A capture machine stuck in the wrong state shows on the edge after the next error. If it fails to leave `CAP_ARMED`, a second error overwrites `frz_data`. If it leaves `CAP_ARMED` too early, `captured` rises with no error present.

A counter that wraps instead of saturating shows as 0 one edge after the sixteenth error. A clear that loses to a simultaneous error shows as a nonzero count or a raised `captured` flag on the very next sample.

Every output is registered, so each fault reaches the ports no later than one diagnostic clock after the edge that causes it.

// File: rtl/ecc_diag_pkg.sv
package ecc_diag_pkg;

    typedef enum logic [1:0] {
        ETYPE_NONE   = 2'b00,
        ETYPE_SINGLE = 2'b01,
        ETYPE_MULTI  = 2'b10
    } etype_t;

    typedef enum logic {
        CAP_ARMED  = 1'b0,
        CAP_FROZEN = 1'b1
    } cap_state_t;

    // Multiple-bit indication dominates the single-bit one.
    function automatic etype_t classify(input logic err, input logic merr);
        if (merr)
            return ETYPE_MULTI;
        else if (err)
            return ETYPE_SINGLE;
        else
            return ETYPE_NONE;
    endfunction

endpackage

// File: rtl/ecc_diag_counter.sv
module ecc_diag_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hit,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;

    always_comb begin
        count_d = count_q;
        if (clr)
            count_d = '0;
        else if (hit && (count_q != CNT_MAX))
            count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else
            count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/ecc_diag_live.sv
module ecc_diag_live #(
    parameter int SYN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SYN_W-1:0] syn_in,
    output logic [SYN_W-1:0] syn_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            syn_q <= '0;
        else
            syn_q <= syn_in;
    end
endmodule

// File: rtl/ecc_diag_capture.sv
module ecc_diag_capture
    import ecc_diag_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              err_in,
    input  logic              merr_in,
    input  logic [CHK_W-1:0]  syn_in,
    input  logic [CHK_W-1:0]  chk_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              captured,
    output logic [CHK_W-1:0]  frz_chk,
    output logic [CHK_W-1:0]  frz_syn,
    output logic [1:0]        frz_type,
    output logic [DATA_W-1:0] frz_data
);
    localparam int REC_W = DATA_W + 2 * CHK_W + 2;

    cap_state_t state_q, state_d;
    logic       hit;
    logic       load;
    logic       wipe;
    logic [REC_W-1:0] rec_q;
    logic [REC_W-1:0] rec_in;

    assign hit    = err_in | merr_in;
    assign rec_in = {data_in, chk_in, syn_in, 2'(classify(err_in, merr_in))};

    // Next-state logic and load controls.
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        wipe    = 1'b0;
        unique case (state_q)
            CAP_ARMED: begin
                if (clr) begin
                    // ARMED_STAY_CLEAR
                    wipe    = 1'b1;
                    state_d = CAP_ARMED;
                end else if (hit) begin
                    // ARMED_TO_FROZEN
                    load    = 1'b1;
                    state_d = CAP_FROZEN;
                end
            end
            CAP_FROZEN: begin
                if (clr) begin
                    // FROZEN_TO_ARMED
                    wipe    = 1'b1;
                    state_d = CAP_ARMED;
                end
            end
            default: begin
                wipe    = 1'b1;
                state_d = CAP_ARMED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CAP_ARMED;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rec_q <= '0;
        else if (wipe)
            rec_q <= '0;
        else if (load)
            rec_q <= rec_in;
    end

    assign captured = (state_q == CAP_FROZEN);
    assign frz_type = rec_q[1:0];
    assign frz_syn  = rec_q[2 +: CHK_W];
    assign frz_chk  = rec_q[2 + CHK_W +: CHK_W];
    assign frz_data = rec_q[2 + 2 * CHK_W +: DATA_W];
endmodule

// File: rtl/ecc_diag_logger.sv
module ecc_diag_logger #(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              err_in,
    input  logic              merr_in,
    input  logic [CHK_W-1:0]  syn_in,
    input  logic [CHK_W-1:0]  chk_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CNT_W-1:0]  err_count,
    output logic              captured,
    output logic [CHK_W-1:0]  frz_chk,
    output logic [CHK_W-1:0]  frz_syn,
    output logic [1:0]        frz_type,
    output logic [DATA_W-1:0] frz_data,
    output logic [CHK_W-1:0]  live_syn
);
    logic hit;
    assign hit = err_in | merr_in;

    ecc_diag_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .hit   (hit),
        .count (err_count)
    );

    ecc_diag_capture #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .err_in   (err_in),
        .merr_in  (merr_in),
        .syn_in   (syn_in),
        .chk_in   (chk_in),
        .data_in  (data_in),
        .captured (captured),
        .frz_chk  (frz_chk),
        .frz_syn  (frz_syn),
        .frz_type (frz_type),
        .frz_data (frz_data)
    );

    ecc_diag_live #(.SYN_W(CHK_W)) u_live (
        .clk    (clk),
        .rst_n  (rst_n),
        .syn_in (syn_in),
        .syn_q  (live_syn)
    );
endmodule

// File: rtl/ecc_diag_checker.sv
module ecc_diag_checker #(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              err_in,
    input logic              merr_in,
    input logic [CHK_W-1:0]  syn_in,
    input logic [CHK_W-1:0]  chk_in,
    input logic [DATA_W-1:0] data_in,
    input logic [CNT_W-1:0]  err_count,
    input logic              captured,
    input logic [CHK_W-1:0]  frz_chk,
    input logic [CHK_W-1:0]  frz_syn,
    input logic [1:0]        frz_type,
    input logic [DATA_W-1:0] frz_data,
    input logic [CHK_W-1:0]  live_syn
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (err_in || merr_in) && err_count != TOP) |=> err_count == $past(err_count) + 1'b1);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && err_count == TOP) |=> err_count == TOP);

    assert_first_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !captured && (err_in || merr_in)) |=>
            (captured && frz_data == $past(data_in) && frz_chk == $past(chk_in) && frz_syn == $past(syn_in)));

    assert_frozen_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && captured) |=>
            ($stable(frz_data) && $stable(frz_chk) && $stable(frz_syn) && $stable(frz_type) && captured));

    assert_live_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> live_syn == $past(syn_in));

    assert_type_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        captured |-> (frz_type == 2'b01 || frz_type == 2'b10));

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (err_count == '0 && !captured && frz_data == '0 && frz_type == 2'b00));

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !captured |-> (frz_data == '0 && frz_chk == '0 && frz_syn == '0 && frz_type == 2'b00));
endmodule

bind ecc_diag_logger ecc_diag_checker #(
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .err_in    (err_in),
    .merr_in   (merr_in),
    .syn_in    (syn_in),
    .chk_in    (chk_in),
    .data_in   (data_in),
    .err_count (err_count),
    .captured  (captured),
    .frz_chk   (frz_chk),
    .frz_syn   (frz_syn),
    .frz_type  (frz_type),
    .frz_data  (frz_data),
    .live_syn  (live_syn)
);

// File: tb/ecc_diag_logger_test.sv
module ecc_diag_logger_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        err_in = 1'b0;
    logic        merr_in = 1'b0;
    logic [7:0]  syn_in = '0;
    logic [7:0]  chk_in = '0;
    logic [63:0] data_in = '0;
    logic [3:0]  err_count;
    logic        captured;
    logic [7:0]  frz_chk;
    logic [7:0]  frz_syn;
    logic [1:0]  frz_type;
    logic [63:0] frz_data;
    logic [7:0]  live_syn;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ecc_diag_logger uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .err_in(err_in), .merr_in(merr_in),
        .syn_in(syn_in), .chk_in(chk_in), .data_in(data_in),
        .err_count(err_count), .captured(captured), .frz_chk(frz_chk),
        .frz_syn(frz_syn), .frz_type(frz_type), .frz_data(frz_data), .live_syn(live_syn)
    );

    typedef struct {
        logic [3:0]  cnt;
        logic        cap;
        logic [7:0]  chk;
        logic [7:0]  syn;
        logic [1:0]  typ;
        logic [63:0] data;
        logic [7:0]  live;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // Reference state, updated per requirement text
    logic [3:0]  m_cnt = '0;
    logic        m_cap = 1'b0;
    logic [7:0]  m_chk = '0;
    logic [7:0]  m_syn = '0;
    logic [1:0]  m_typ = '0;
    logic [63:0] m_data = '0;
    logic [7:0]  m_live = '0;

    task automatic chk_val(input string tag, input string fld, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, fld, act, exp, $time);
        end
    endtask

    task automatic step(input logic e, input logic m, input logic [7:0] s, input logic [7:0] c,
                        input logic [63:0] d, input logic cl, input string tag);
        exp_t it;
        @(negedge clk);
        err_in = e; merr_in = m; syn_in = s; chk_in = c; data_in = d; clr = cl;
        m_live = s;
        if (cl) begin
            m_cnt = '0; m_cap = 1'b0; m_chk = '0; m_syn = '0; m_typ = '0; m_data = '0;
        end else if (e || m) begin
            if (m_cnt != 4'hF) m_cnt = m_cnt + 1'b1;
            if (!m_cap) begin
                m_cap = 1'b1; m_chk = c; m_syn = s; m_data = d;
                m_typ = m ? 2'b10 : 2'b01;
            end
        end
        it.cnt = m_cnt; it.cap = m_cap; it.chk = m_chk; it.syn = m_syn;
        it.typ = m_typ; it.data = m_data; it.live = m_live; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compares 5 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk_val(e.tag, "err_count", 64'(err_count), 64'(e.cnt));
                chk_val(e.tag, "captured",  64'(captured),  64'(e.cap));
                chk_val(e.tag, "frz_chk",   64'(frz_chk),   64'(e.chk));
                chk_val(e.tag, "frz_syn",   64'(frz_syn),   64'(e.syn));
                chk_val(e.tag, "frz_type",  64'(frz_type),  64'(e.typ));
                chk_val(e.tag, "frz_data",  frz_data,       e.data);
                chk_val(e.tag, "live_syn",  64'(live_syn),  64'(e.live));
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs zero during reset, even with busy inputs
        syn_in = 8'h5A; err_in = 1'b1; data_in = 64'hDEAD;
        repeat (3) @(posedge clk);
        #5;
        chk_val("R1", "err_count", 64'(err_count), 0);
        chk_val("R1", "captured", 64'(captured), 0);
        chk_val("R1", "frz_data", frz_data, 0);
        chk_val("R1", "live_syn", 64'(live_syn), 0);
        @(negedge clk);
        err_in = 0; syn_in = 0; data_in = 0;
        rst_n = 1'b1;

        // R6 / R9: idle edges with changing syndrome
        for (int i = 0; i < 4; i++)
            step(1'b0, 1'b0, 8'(8'h11 * (i + 1)), 8'hC3, 64'h1234, 1'b0, "R9_R6_idle");

        // R4 / R7: first single-bit error captured
        step(1'b1, 1'b0, 8'h3C, 8'hA5, 64'h0123_4567_89AB_CDEF, 1'b0, "R4_R7_single");
        // R5 / R2: later errors counted but frozen set holds
        step(1'b1, 1'b1, 8'hFF, 8'h00, 64'hFFFF_0000_FFFF_0000, 1'b0, "R5_R2_later_multi");
        step(1'b0, 1'b0, 8'h77, 8'h11, 64'h0, 1'b0, "R5_R6_quiet");
        step(1'b1, 1'b0, 8'h01, 8'h02, 64'h5555, 1'b0, "R5_R2_later_single");

        // R8: clear
        step(1'b0, 1'b0, 8'h10, 8'h20, 64'h0, 1'b1, "R8_clear");
        // R8: clear with simultaneous error is not counted or captured
        step(1'b1, 1'b1, 8'h99, 8'h88, 64'hCAFE_F00D, 1'b1, "R8_clear_with_error");
        step(1'b0, 1'b0, 8'h42, 8'h24, 64'h0, 1'b0, "R9_after_clear");

        // R7: merr alone gives type 2'b10
        step(1'b0, 1'b1, 8'hE1, 8'h1E, 64'hA5A5_A5A5_5A5A_5A5A, 1'b0, "R7_merr_only");
        step(1'b0, 1'b0, 8'h00, 8'h00, 64'h0, 1'b1, "R8_clear2");
        // R7: both flags give type 2'b10
        step(1'b1, 1'b1, 8'h6B, 8'hB6, 64'h8000_0000_0000_0001, 1'b0, "R7_both_flags");

        // R2 / R3: long error burst saturates at 15
        for (int i = 0; i < 20; i++)
            step(1'b1, 1'b0, 8'(i), 8'(i + 3), 64'(i * 7), 1'b0, "R2_R3_burst");
        step(1'b0, 1'b0, 8'h5E, 8'h00, 64'h0, 1'b0, "R3_hold_idle");
        step(1'b0, 1'b0, 8'h00, 8'h00, 64'h0, 1'b1, "R8_final_clear");
        step(1'b1, 1'b0, 8'h2D, 8'hD2, 64'h0F0F, 1'b0, "R4_rearmed");

        @(negedge clk);
        err_in = 0; merr_in = 0; clr = 0;
        repeat (3) @(posedge clk);
        #6;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule